// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Data Inversion and Clock Pin Steering

This block moves 8-bit frames over a synchronous serial link. It generates the shift clock itself from the system clock through a fixed divider. A host loads a transmit byte through a one-entry holding register, and the byte goes out on the serial data line. At the same time the receive side assembles a byte from the serial input, using the same shift clock, and raises a completion flag when the byte is ready. All pins are registered and the reset is synchronous and active high.

Per-frame configuration inputs set four things: the bit order, which clock edge launches data, whether the data is logically inverted, and which of two clock output pins drives the peer. With inversion on, the line carries the complement of the written byte. A received byte is complemented again before the host sees it, so an inverted link reads back true data. The clock steering sends the shift clock to one of two pins, and the other pin stays at its idle-high level. This lets two peers share one data line, with only the clocked peer taking part in the exchange. All configuration inputs are captured when a frame starts, so changing them during a frame has no effect on that frame.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, both clock pins and `sdo` are 1, `tx_empty` is 1, `rx_done` is 0 and `rd_data` is 0.
- R2: A write sets the holding register and drops `tx_empty` in the next cycle. The held byte starts a frame as soon as the shifter is idle, and `tx_empty` returns to 1 when that happens. A write while the holding register is full is ignored.
- R3: With `cfg_msb_first` = 0, bit 0 of the line byte is sent first and bit 7 last. With `cfg_msb_first` = 1, bit 7 is sent first. The receiver places incoming bits in the same order.
- R4: With `cfg_invert` = 1, the line carries the bitwise complement of the written byte. With `cfg_invert` = 0, it carries the byte unchanged.
- R5: With `cfg_invert` = 1, `rd_data` is the complement of the assembled line byte. With `cfg_invert` = 0, it is the line byte itself.
- R6: With `cfg_launch_rise` = 0, `sdo` changes only with a falling clock edge and `sdi` is sampled on the rising edge. With `cfg_launch_rise` = 1, the first bit is driven at frame start, later bits change only with a rising edge, and `sdi` is sampled on the falling edge.
- R7: A frame has exactly 8 clock periods. Each half period lasts HALF_DIV system clocks, the clock starts with a falling edge, and the clock idles high between frames.
- R8: With `cfg_multi_pin` = 0, or with `cfg_multi_pin` = 1 and `cfg_pin_sel` = 0, the clock appears on `sclk_a`. With `cfg_multi_pin` = 1 and `cfg_pin_sel` = 1, it appears on `sclk_b`. The unselected pin stays at 1 for the whole frame.
- R9: `rx_done` sets in the cycle of the 8th sample edge and `rd_data` is updated at the same time. `rd_en` clears `rx_done`, but a set in the same cycle wins over the clear.
- R10: Between frames, `sdo` holds the last bit of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_invert | input | 1 | 1 = invert data in both directions |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_launch_rise | input | 1 | 1 = launch on rising edge, sample on falling edge |
| cfg_multi_pin | input | 1 | 1 = clock pin chosen by cfg_pin_sel |
| cfg_pin_sel | input | 1 | 0 = sclk_a, 1 = sclk_b (when cfg_multi_pin = 1) |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Transmit byte |
| rd_en | input | 1 | Read strobe, clears rx_done |
| rd_data | output | DATA_W | Last received byte |
| tx_empty | output | 1 | Holding register is free |
| rx_done | output | 1 | A received byte is waiting |
| sclk_a | output | 1 | Shift clock output pin A |
| sclk_b | output | 1 | Shift clock output pin B |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The eighth receive sample sets `rx_done`, and a host read clears it. Both can land on the same clock edge. The bench holds `rd_en` high for a whole frame so that a clear request is present on the edge where the last bit is sampled. A monitor records `rx_done` at exactly that edge. The flag must read 1 there, because the set wins, and it must fall one cycle later once only the clear remains.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef struct packed {
    logic multi;
    logic sel;
  } pin_route_t;

  function automatic logic route_to_b(pin_route_t r);
    return r.multi && r.sel;
  endfunction
endpackage

// File: rtl/sxc_clkgen.sv
module sxc_clkgen #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic sclk_q,
  output logic fall_p,
  output logic rise_p,
  output logic last_p
);
  localparam int CW    = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int EDGES = 2 * DATA_W;
  localparam int ECW   = $clog2(EDGES);

  logic [CW-1:0]  div_cnt;
  logic [ECW-1:0] edge_cnt;
  logic           tick;

  assign tick   = busy && (div_cnt == CW'(HALF_DIV - 1));
  assign fall_p = tick && sclk_q;
  assign rise_p = tick && !sclk_q;
  assign last_p = rise_p && (edge_cnt == ECW'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sclk_q   <= 1'b1;
      div_cnt  <= '0;
      edge_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        div_cnt  <= '0;
        edge_cnt <= '0;
      end
    end else if (tick) begin
      div_cnt  <= '0;
      sclk_q   <= ~sclk_q;
      edge_cnt <= edge_cnt + 1'b1;
      if (last_p) busy <= 1'b0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_FRAME_ENDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> sclk_q); // R7
endmodule

// File: rtl/sxc_tx.sv
module sxc_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              launch_rise,
  input  logic              fall_p,
  input  logic              rise_p,
  input  logic              last_p,
  output logic              sdo
);
  logic [DATA_W-1:0] reversed;
  logic [DATA_W-1:0] ordered;
  logic [DATA_W-1:0] sh;
  logic              rise_mode_q;
  logic              adv;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign reversed[i] = load_data[DATA_W-1-i];
  end

  assign ordered = msb_first ? reversed : load_data;
  assign adv     = rise_mode_q ? (rise_p && !last_p) : fall_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      sdo         <= 1'b1;
      rise_mode_q <= 1'b0;
    end else if (load) begin
      rise_mode_q <= launch_rise;
      if (launch_rise) begin
        sdo <= ordered[0];
        sh  <= ordered >> 1;
      end else begin
        sh <= ordered;
      end
    end else if (adv) begin
      sdo <= sh[0];
      sh  <= sh >> 1;
    end
  end

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(load || adv) |=> $stable(sdo)); // R6
endmodule

// File: rtl/sxc_rx.sv
module sxc_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              invert,
  input  logic              msb_first,
  input  logic              launch_rise,
  input  logic              fall_p,
  input  logic              rise_p,
  input  logic              sdi,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done
);
  localparam int CNTW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] assembled;
  logic [CNTW-1:0]   cnt;
  logic              inv_q, msb_q, rise_mode_q;
  logic              sample, final_bit;

  assign sample    = rise_mode_q ? fall_p : rise_p;
  assign final_bit = sample && (cnt == CNTW'(DATA_W - 1));
  assign assembled = msb_q ? {sh[DATA_W-2:0], sdi} : {sdi, sh[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      cnt         <= '0;
      inv_q       <= 1'b0;
      msb_q       <= 1'b0;
      rise_mode_q <= 1'b0;
    end else if (start) begin
      cnt         <= '0;
      inv_q       <= invert;
      msb_q       <= msb_first;
      rise_mode_q <= launch_rise;
    end else if (sample) begin
      sh  <= assembled;
      cnt <= final_bit ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_done <= 1'b0;
    end else if (final_bit) begin
      rx_data <= assembled ^ {DATA_W{inv_q}};
      rx_done <= 1'b1;
    end else if (rd_en) begin
      rx_done <= 1'b0;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(final_bit)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !final_bit) |=> !rx_done); // R9
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_invert,
  input  logic              cfg_msb_first,
  input  logic              cfg_launch_rise,
  input  logic              cfg_multi_pin,
  input  logic              cfg_pin_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_empty,
  output logic              rx_done,
  output logic              sclk_a,
  output logic              sclk_b,
  output logic              sdo,
  input  logic              sdi
);
  import sxc_pkg::*;

  logic [DATA_W-1:0] hold_data;
  logic              hold_valid;
  logic              busy, sclk_q, fall_p, rise_p, last_p;
  logic              start, sclk_nxt, route_b;
  pin_route_t        route_q;

  assign start    = hold_valid && !busy;
  assign sclk_nxt = sclk_q ^ (fall_p | rise_p);
  assign route_b  = route_to_b(route_q);
  assign tx_empty = !hold_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (start) begin
      hold_valid <= 1'b0;
    end else if (wr_en && !hold_valid) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
      sclk_a  <= 1'b1;
      sclk_b  <= 1'b1;
    end else begin
      if (start) route_q <= '{multi: cfg_multi_pin, sel: cfg_pin_sel};
      sclk_a <= route_b ? 1'b1 : sclk_nxt;
      sclk_b <= route_b ? sclk_nxt : 1'b1;
    end
  end

  sxc_clkgen #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) clkgen_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .sclk_q(sclk_q),
    .fall_p(fall_p), .rise_p(rise_p), .last_p(last_p)
  );

  sxc_tx #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst(rst), .load(start),
    .load_data(hold_data ^ {DATA_W{cfg_invert}}),
    .msb_first(cfg_msb_first), .launch_rise(cfg_launch_rise),
    .fall_p(fall_p), .rise_p(rise_p), .last_p(last_p), .sdo(sdo)
  );

  sxc_rx #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst(rst), .start(start), .invert(cfg_invert),
    .msb_first(cfg_msb_first), .launch_rise(cfg_launch_rise),
    .fall_p(fall_p), .rise_p(rise_p), .sdi(sdi), .rd_en(rd_en),
    .rx_data(rd_data), .rx_done(rx_done)
  );

  AST_UNSEL_A_IDLE: assert property (@(posedge clk) disable iff (rst)
    route_b |=> sclk_a); // R8
  AST_UNSEL_B_IDLE: assert property (@(posedge clk) disable iff (rst)
    !route_b |=> sclk_b); // R8
  AST_HOLD_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && !start) |=> $stable(hold_data)); // R2
endmodule

// File: tb/sync_serial_xcvr_tb_top.sv
module sync_serial_xcvr_tb_top;
  localparam int W  = 8;
  localparam int HD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_invert = 0, cfg_msb_first = 0, cfg_launch_rise = 0;
  logic cfg_multi_pin = 0, cfg_pin_sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic tx_empty, rx_done, sclk_a, sclk_b, sdo, sdi;

  logic [W-1:0] mask = '0;
  int  ncap = 0, falls_a = 0, falls_b = 0, low_cnt = 0, bad_launch = 0, nfall_act = 0;
  logic cap [0:15];
  logic exp_b = 0, mon_pol = 0, mon_on = 0, done_at_last = 0;
  logic prev_a = 1, prev_b = 1, prev_sdo = 1;
  int n_chk = 0, n_bad = 0, cycles = 0;

  assign sdi = sdo ^ mask[ncap % 8];

  always #2.5 clk = ~clk;

  sync_serial_xcvr #(.DATA_W(W), .HALF_DIV(HD)) dut_i (
    .clk(clk), .rst(rst), .cfg_invert(cfg_invert), .cfg_msb_first(cfg_msb_first),
    .cfg_launch_rise(cfg_launch_rise), .cfg_multi_pin(cfg_multi_pin),
    .cfg_pin_sel(cfg_pin_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .tx_empty(tx_empty), .rx_done(rx_done),
    .sclk_a(sclk_a), .sclk_b(sclk_b), .sdo(sdo), .sdi(sdi)
  );

  // monitor of the pins, at the falling system clock edge
  always @(negedge clk) begin
    logic act, pact, fall_act, rise_act;
    act  = exp_b ? sclk_b : sclk_a;
    pact = exp_b ? prev_b : prev_a;
    fall_act = pact && !act;
    rise_act = !pact && act;
    if (mon_on) begin
      if (prev_a && !sclk_a) falls_a++;
      if (prev_b && !sclk_b) falls_b++;
      if (!act) low_cnt++;
      if (fall_act) nfall_act++;
      if (sdo !== prev_sdo) begin
        if (mon_pol ? (!rise_act && nfall_act > 0) : !fall_act) bad_launch++;
      end
      if (mon_pol ? fall_act : rise_act) begin
        if (ncap < 16) cap[ncap] = sdo;
        ncap++;
        if (ncap % 8 == 0) done_at_last = rx_done;
      end
    end
    prev_a = sclk_a; prev_b = sclk_b; prev_sdo = sdo;
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 150000);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [W-1:0] line_seq(input logic [W-1:0] d, input logic inv, input logic msb);
    logic [W-1:0] l, s;
    l = inv ? ~d : d;
    for (int k = 0; k < W; k++) s[k] = msb ? l[W-1-k] : l[k];
    return s;
  endfunction

  function automatic logic [W-1:0] rev8(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = v[W-1-k];
    return r;
  endfunction

  task automatic mon_reset(input logic b, input logic pol);
    exp_b = b; mon_pol = pol;
    ncap = 0; falls_a = 0; falls_b = 0; low_cnt = 0; bad_launch = 0; nfall_act = 0;
    done_at_last = 0; mon_on = 1;
  endtask

  task automatic wait_caps(input int n);
    int g = 0;
    while (ncap < n && g < 5000) begin step(1); g++; end
  endtask

  task automatic test_reset();
    rst = 1; step(3); rst = 0; step(1);
    chk(sclk_a === 1 && sclk_b === 1, "R1 clock pins idle", {sclk_a, sclk_b}, 3);
    chk(sdo === 1, "R1 sdo", sdo, 1);
    chk(tx_empty === 1, "R1 tx_empty", tx_empty, 1);
    chk(rx_done === 0, "R1 rx_done", rx_done, 0);
    chk(rd_data === 0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic run_frame(input logic [W-1:0] d, input logic inv, input logic msb,
                           input logic pol, input logic multi, input logic sel,
                           input logic [W-1:0] m);
    logic [W-1:0] es, got, erx;
    logic b;
    b = multi && sel;
    cfg_invert = inv; cfg_msb_first = msb; cfg_launch_rise = pol;
    cfg_multi_pin = multi; cfg_pin_sel = sel; mask = m;
    mon_reset(b, pol);
    wr_data = d; wr_en = 1; step(1); wr_en = 0;
    chk(tx_empty === 0, "R2 tx_empty after write", tx_empty, 0);
    step(1);
    // configuration changes now; the frame must keep its captured settings
    cfg_invert = ~inv; cfg_msb_first = ~msb; cfg_launch_rise = ~pol; cfg_pin_sel = ~sel;
    chk(tx_empty === 1, "R2 tx_empty after start", tx_empty, 1);
    wait_caps(8);
    step(2 * HD + 4);
    es = line_seq(d, inv, msb);
    for (int k = 0; k < W; k++) got[k] = cap[k];
    chk(got === es, msb ? "R3/R4 line order msb" : "R3/R4 line order lsb", got, es);
    chk(bad_launch == 0, pol ? "R6 rise launch" : "R6 fall launch", bad_launch, 0);
    chk(low_cnt == W * HD, "R7 low time", low_cnt, W * HD);
    chk((b ? falls_b : falls_a) == W, "R8 selected pin pulses", b ? falls_b : falls_a, W);
    chk((b ? falls_a : falls_b) == 0, "R8 unselected pin idle", b ? falls_a : falls_b, 0);
    erx = d ^ (msb ? rev8(m) : m);
    chk(rx_done === 1, "R9 rx_done set", rx_done, 1);
    chk(rd_data === erx, "R5/R3 rx byte", rd_data, erx);
    chk(sdo === es[W-1], "R10 sdo holds last bit", sdo, es[W-1]);
    rd_en = 1; step(1); rd_en = 0;
    chk(rx_done === 0, "R9 read clears", rx_done, 0);
    mon_on = 0;
  endtask

  task automatic test_collision();
    cfg_invert = 0; cfg_msb_first = 0; cfg_launch_rise = 0;
    cfg_multi_pin = 0; cfg_pin_sel = 0; mask = '0;
    mon_reset(1'b0, 1'b0);
    rd_en = 1;
    wr_data = 8'h3C; wr_en = 1; step(1); wr_en = 0;
    wait_caps(8);
    step(1);
    chk(done_at_last === 1, "R9 set wins over clear", done_at_last, 1);
    chk(rx_done === 0, "R9 cleared after collision", rx_done, 0);
    rd_en = 0; mon_on = 0;
    step(2 * HD + 4);
  endtask

  task automatic test_back_to_back();
    logic [W-1:0] got, es;
    cfg_invert = 0; cfg_msb_first = 0; cfg_launch_rise = 0;
    cfg_multi_pin = 0; cfg_pin_sel = 0; mask = '0;
    mon_reset(1'b0, 1'b0);
    wr_data = 8'h96; wr_en = 1; step(1); wr_en = 0;
    step(3);
    wr_data = 8'h4B; wr_en = 1; step(1);
    chk(tx_empty === 0, "R2 second byte held", tx_empty, 0);
    wr_data = 8'hE1; step(1); wr_en = 0;
    wait_caps(16);
    step(2 * HD + 4);
    es = line_seq(8'h4B, 1'b0, 1'b0);
    for (int k = 0; k < W; k++) got[k] = cap[8 + k];
    chk(got === es, "R2 held byte sent, extra write ignored", got, es);
    chk(rd_data === 8'h4B, "R2 second received byte", rd_data, 8'h4B);
    chk(tx_empty === 1, "R2 tx_empty after drain", tx_empty, 1);
    rd_en = 1; step(1); rd_en = 0; mon_on = 0;
  endtask

  initial begin
    test_reset();
    run_frame(8'hA5, 0, 0, 0, 0, 0, 8'h00);
    run_frame(8'h1E, 1, 0, 0, 0, 1, 8'h00);
    run_frame(8'hC3, 0, 1, 1, 1, 1, 8'h00);
    run_frame(8'h71, 1, 1, 0, 1, 0, 8'h0F);
    run_frame(8'h2D, 0, 0, 1, 1, 1, 8'h81);
    run_frame(8'hF0, 1, 1, 1, 0, 1, 8'h35);
    test_collision();
    test_back_to_back();
    finish_up();
  end
endmodule